// File: doc/BRIEF.md
# Signed-Digit Constant FIR Filter

This block is an eight-tap direct-form FIR filter whose coefficients are fixed when the design is built. Samples are signed 16-bit fixed-point values. They arrive with a valid strobe, and each accepted sample yields exactly one filtered result. The result is the dot product of the newest sample and the seven samples before it with the coefficient set.

No general multiplier is used. When the design is elaborated, each coefficient is recoded into canonic signed-digit form. Every non-zero digit then becomes one shifted copy of a tap sample. A negative digit becomes the bit-inverted copy together with a +1 correction. All these rows are reduced in carry-save form to a sum row and a carry row. A register bank sits halfway through the reduction. A single carry-propagate adder produces the full-precision 35-bit result.

Coefficients are Q1.15 values passed as one packed parameter, with tap 0 in the least significant 16 bits. The output keeps every product bit and is not rounded.

Top module: `fir_csd_top`

## Requirements
- R1: While reset is low, and in the first cycle after it, `validOut` is 0 and `dataOut` is 0. Reset empties the sample history, so the first output after reset equals c0 times the first accepted sample.
- R2: For an accepted sample x[n], the output is the exact sum over k=0..7 of c_k·x[n−k] as a 35-bit two's-complement number. Samples that are older than the history are zero.
- R3: A sample is accepted on a rising clock edge where `validIn` is 1. `validOut` is 1 for exactly one cycle, two rising edges later, and carries that sample's result. Every accepted sample produces one output, and no output appears without an accepted sample.
- R4: On an edge where `validIn` is 0, `sampleIn` is ignored and the history does not move. The next output is the same as if the idle cycles had not occurred.
- R5: While `validOut` is 0, `dataOut` keeps the last result it carried.
- R6: By default, c0..c7 are −32768, 3277, 9830, 16384, 32767, −9830, 3277, −1638 (Q1.15). c0 applies to the newest sample and c7 to the oldest.
- R7: Inputs of −32768 and 32767 in any combination give the exact result with no wrap or saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Sample strobe |
| sampleIn | input | 16 | Signed input sample |
| validOut | output | 1 | Result strobe, two cycles after the accepted sample |
| dataOut | output | 35 | Signed full-precision filter result |

## Verification
Single impulses of both extreme amplitudes are walked through the delay line. Each output then equals one coefficient, which catches a wrong tap order, a wrong coefficient, or a wrong recoding of a +1 or −1 digit. Walking single bits and a stepped sweep across the whole input range expose errors in sign extension, shift, and inversion correction that depend on the sample value. Long runs of extreme values, including patterns that follow the coefficient signs, drive the sum to its largest magnitude and expose truncated precision. Random strobes with junk data in the idle cycles, plus a reset in the middle of a stream, separate correct history handling from a delay line that shifts on every clock or survives reset.

// File: rtl/fir_csd_pkg.sv
package fir_csd_pkg;

  typedef struct packed {
    logic load;      // shift a new sample into the history
    logic stage1En;  // capture the per-tap carry-save rows
    logic outEn;     // capture the final sum
  } ctrlStrobes_t;

  // Canonic signed-digit recoding of a constant.
  // Returns a mask of the +1 digits (wantNeg=0) or of the -1 digits (wantNeg=1).
  function automatic logic [63:0] csdDigits(input longint value, input int width,
                                            input bit wantNeg);
    longint x;
    logic [63:0] mask;
    x = value;
    mask = '0;
    for (int i = 0; i < width; i++) begin
      if (x[0]) begin
        if (!x[1]) begin
          if (!wantNeg) mask[i] = 1'b1;
          x = x - 1;
        end else begin
          if (wantNeg) mask[i] = 1'b1;
          x = x + 1;
        end
      end
      x = x >>> 1;
    end
    return mask;
  endfunction

endpackage

// File: rtl/fir_csd_ctrl.sv
module fir_csd_ctrl
  import fir_csd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  output ctrlStrobes_t ctrl,
  output logic         validOut
);

  logic validStage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validStage1 <= 1'b0;
      validOut    <= 1'b0;
    end else begin
      validStage1 <= validIn;
      validOut    <= validStage1;
    end
  end

  always_comb begin
    ctrl.load     = validIn;
    ctrl.stage1En = validIn;
    ctrl.outEn    = validStage1;
  end

endmodule

// File: rtl/fir_csd_datapath.sv
module fir_csd_datapath
  import fir_csd_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 35,
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             ctrl,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic        [OUT_W-1:0]  sumOut
);

  localparam int CSD_W = COEF_W + 1;

  logic signed [DATA_W-1:0] histReg [TAPS-1];
  logic signed [DATA_W-1:0] tapVal  [TAPS];
  logic [OUT_W-1:0] rowSum   [TAPS];
  logic [OUT_W-1:0] rowCarry [TAPS];
  logic [OUT_W-1:0] stSum    [TAPS];
  logic [OUT_W-1:0] stCarry  [TAPS];
  logic [OUT_W-1:0] finSum, finCarry, carryTmp;

  // history: tap 0 is the sample being presented, older taps are registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS-1; k++) histReg[k] <= '0;
    end else if (ctrl.load) begin
      histReg[0] <= sampleIn;
      for (int k = 1; k < TAPS-1; k++) histReg[k] <= histReg[k-1];
    end
  end

  always_comb begin
    tapVal[0] = sampleIn;
    for (int k = 1; k < TAPS; k++) tapVal[k] = histReg[k-1];
  end

  // per-tap signed-digit rows compressed to one sum/carry pair
  for (genvar t = 0; t < TAPS; t++) begin : gTap
    localparam longint COEF_VAL = longint'($signed(COEFS[t*COEF_W +: COEF_W]));
    localparam logic [CSD_W-1:0] POS_DIG = CSD_W'(csdDigits(COEF_VAL, CSD_W, 1'b0));
    localparam logic [CSD_W-1:0] NEG_DIG = CSD_W'(csdDigits(COEF_VAL, CSD_W, 1'b1));
    localparam logic [OUT_W-1:0] CORR_ROW = OUT_W'($countones(NEG_DIG));

    logic [OUT_W-1:0] extVal;
    logic [OUT_W-1:0] ppRow [CSD_W];
    logic [OUT_W-1:0] accS, accC, accT;

    assign extVal = {{(OUT_W-DATA_W){tapVal[t][DATA_W-1]}}, tapVal[t]};

    for (genvar d = 0; d < CSD_W; d++) begin : gDigit
      if (POS_DIG[d]) begin : gPos
        assign ppRow[d] = extVal << d;
      end else if (NEG_DIG[d]) begin : gNeg
        assign ppRow[d] = ~(extVal << d);
      end else begin : gZero
        assign ppRow[d] = '0;
      end
    end

    always_comb begin
      accS = CORR_ROW;
      accC = ppRow[0];
      for (int d = 1; d < CSD_W; d++) begin
        accT = ((accS & accC) | (accS & ppRow[d]) | (accC & ppRow[d])) << 1;
        accS = accS ^ accC ^ ppRow[d];
        accC = accT;
      end
    end

    assign rowSum[t]   = accS;
    assign rowCarry[t] = accC;
  end

  // pipeline cut inside the reduction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < TAPS; t++) begin
        stSum[t]   <= '0;
        stCarry[t] <= '0;
      end
    end else if (ctrl.stage1En) begin
      for (int t = 0; t < TAPS; t++) begin
        stSum[t]   <= rowSum[t];
        stCarry[t] <= rowCarry[t];
      end
    end
  end

  // second reduction level across taps
  always_comb begin
    finSum   = '0;
    finCarry = '0;
    for (int t = 0; t < TAPS; t++) begin
      carryTmp = ((finSum & finCarry) | (finSum & stSum[t]) | (finCarry & stSum[t])) << 1;
      finSum   = finSum ^ finCarry ^ stSum[t];
      finCarry = carryTmp;
      carryTmp = ((finSum & finCarry) | (finSum & stCarry[t]) | (finCarry & stCarry[t])) << 1;
      finSum   = finSum ^ finCarry ^ stCarry[t];
      finCarry = carryTmp;
    end
  end

  // single carry-propagate adder
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sumOut <= '0;
    else if (ctrl.outEn) sumOut <= finSum + finCarry;
  end

endmodule

// File: rtl/fir_csd_top.sv
module fir_csd_top
  import fir_csd_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter logic [TAPS*COEF_W-1:0] COEFS =
    128'hF99A_0CCD_D99A_7FFF_4000_2666_0CCD_8000,
  localparam int OUT_W = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              validOut,
  output logic [OUT_W-1:0]  dataOut
);

  ctrlStrobes_t ctrl;

  fir_csd_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .ctrl     (ctrl),
    .validOut (validOut)
  );

  fir_csd_datapath #(
    .TAPS   (TAPS),
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .OUT_W  (OUT_W),
    .COEFS  (COEFS)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .sampleIn (sampleIn),
    .sumOut   (dataOut)
  );

endmodule

// File: rtl/fir_csd_chk.sv
module fir_csd_chk #(
  parameter int OUT_W = 35
) (
  input logic             clk,
  input logic             rstN,
  input logic             validIn,
  input logic             validOut,
  input logic [OUT_W-1:0] dataOut
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (!validOut && dataOut == '0)); // R1

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && validOut) |-> $past(validIn, 2)); // R3

  AST_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && $past(validIn, 2)) |-> validOut); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && !validOut) |-> $stable(dataOut)); // R5

endmodule

bind fir_csd_top fir_csd_chk #(.OUT_W(OUT_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .validIn  (validIn),
  .validOut (validOut),
  .dataOut  (dataOut)
);

// File: tb/sim_fir_csd_top.sv
module sim_fir_csd_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 8;
  localparam int COEF_REF [TAPS] = '{-32768, 3277, 9830, 16384, 32767, -9830, 3277, -1638};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic [15:0] sampleIn = '0;
  logic validOut;
  logic [34:0] dataOut;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  bit done = 1'b0;
  bit inReset = 1'b1;
  string phaseTag = "R2";
  longint hist [TAPS];
  longint expQ [$];
  int dueQ [$];
  longint lastOut = 0;

  fir_csd_top u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .sampleIn(sampleIn),
    .validOut(validOut), .dataOut(dataOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycleCnt++;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycleCnt);
    end
  endtask

  function automatic longint outVal();
    return longint'($signed(dataOut));
  endfunction

  // output monitor
  always @(negedge clk) begin
    if (!inReset && rstN) begin
      if (validOut) begin
        if (expQ.size() == 0) begin
          check("R3 unexpected output", 1, 0);
        end else begin
          longint e;
          int due;
          e = expQ.pop_front();
          due = dueQ.pop_front();
          check(phaseTag, outVal(), e);
          check("R3 latency", cycleCnt, due);
        end
        lastOut = outVal();
      end else begin
        check("R5 hold", outVal(), lastOut);
      end
    end
  end

  task automatic push(input logic [15:0] x, input bit v);
    @(negedge clk);
    validIn = v;
    sampleIn = x;
    if (v) begin
      longint acc;
      for (int k = TAPS-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'($signed(x));
      acc = 0;
      for (int k = 0; k < TAPS; k++) acc += longint'(COEF_REF[k]) * hist[k];
      expQ.push_back(acc);
      dueQ.push_back(cycleCnt + 2);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    inReset = 1'b1;
    rstN = 1'b0;
    validIn = 1'b0;
    sampleIn = 16'hA5A5;
    expQ.delete();
    dueQ.delete();
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    lastOut = 0;
    repeat (2) @(negedge clk);
    check("R1 validOut in reset", longint'(validOut), 0);
    check("R1 dataOut in reset", outVal(), 0);
    rstN = 1'b1;
    inReset = 1'b0;
    @(negedge clk);
    check("R1 validOut after reset", longint'(validOut), 0);
    check("R1 dataOut after reset", outVal(), 0);
  endtask

  task automatic flushZeros();
    for (int i = 0; i < TAPS; i++) push(16'h0000, 1'b1);
  endtask

  initial begin
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    doReset();

    // R1: first output uses an empty history
    phaseTag = "R1 first output";
    push(16'd100, 1'b1);
    push(16'd0, 1'b0);
    push(16'd0, 1'b0);

    // R6: impulses walk each coefficient out in tap order
    phaseTag = "R6 impulse";
    flushZeros();
    push(16'h7FFF, 1'b1);
    flushZeros();
    push(16'h8000, 1'b1);
    flushZeros();
    push(16'h0001, 1'b1);
    flushZeros();

    // R7: extreme values, including sign-matched worst case
    phaseTag = "R7 extremes";
    for (int i = 0; i < 12; i++) push(16'h7FFF, 1'b1);
    for (int i = 0; i < 12; i++) push(16'h8000, 1'b1);
    for (int i = 0; i < 24; i++) push((i % 2 == 0) ? 16'h7FFF : 16'h8000, 1'b1);
    for (int r = 0; r < 2; r++) begin
      for (int k = TAPS-1; k >= 0; k--) begin
        bit pos;
        pos = (COEF_REF[k] >= 0) ^ r[0];
        push(pos ? 16'h7FFF : 16'h8000, 1'b1);
      end
    end

    // R2: walking bits and a stepped sweep over the input range
    phaseTag = "R2 sweep";
    for (int b = 0; b < 16; b++) begin
      push(16'(1 << b), 1'b1);
      push(16'(~(1 << b)), 1'b1);
    end
    for (int v = -32768; v < 32768; v += 37) push(16'(v), 1'b1);

    // R4: random strobes, junk data on idle cycles
    phaseTag = "R4 gaps";
    for (int i = 0; i < 1500; i++) push(16'($urandom), ($urandom % 2) == 1);
    for (int i = 0; i < 4; i++) push(16'($urandom), 1'b0);

    // R1: reset in the middle of a stream clears history
    for (int i = 0; i < 5; i++) push(16'($urandom), 1'b1);
    doReset();
    phaseTag = "R1 history cleared";
    push(16'h8000, 1'b1);
    push(16'h1234, 1'b0);
    push(16'h4321, 1'b0);
    push(16'h0000, 1'b0);

    // R3: every accepted sample produced its output
    check("R3 pending outputs", longint'(expQ.size()), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule